// File: doc/BRIEF.md
# Clamped-Window Activation Table

This block turns a neuron's 16-bit fixed-point weighted sum into a 16-bit activation value by lookup. The stored function is assumed monotonic and sigmoid-like, so only its rising part is kept. That part covers 4096 consecutive signed input codes centred on zero. A sum that falls below this window returns the first stored word, and a sum above it returns the last. The table therefore needs 4096 words rather than one word for each of the 65536 possible inputs.

A single read port serves a whole column of neuron blocks. Only one block in a column fires in any cycle, so the column presents at most one request per clock. A request is registered at the clock edge, and the looked-up word appears one cycle later with a valid flag. A host write port fills the table before use and can rewrite any word while reads continue. If a write and a read hit the same word in the same cycle, the read returns the word as it stood before the write.

A two-state controller tracks the response slot. In **ST_IDLE** no response is presented. The transition *accept* (a request seen at an edge) moves it to **ST_SERVE**. The transition *chain* (another request while in ST_SERVE) keeps it in ST_SERVE. The transition *drain* (no request at the edge) returns it to ST_IDLE.

Top module: `act_window_lut`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `rsp_act` is 0.
- R2: A request sampled at a clock edge makes `rsp_valid` 1 during the following cycle. A cycle with no request at its edge has `rsp_valid` 0. Back-to-back requests give back-to-back responses.
- R3: A sum `s` read as two's complement with -2048 <= s <= 2047 returns table word `s + 2048`.
- R4: A sum below -2048, down to -32768, returns table word 0.
- R5: A sum above 2047, up to 32767, returns table word 4095.
- R6: In a cycle that follows an edge with no request, `rsp_act` keeps its previous value, including while host writes are taking place.
- R7: A host write to address `a` changes the value that reads of word `a` return from the next cycle on, and leaves every other word unchanged.
- R8: When a host write and a read select the same word at the same edge, the response carries the word's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A lookup request is present this cycle |
| req_sum | input | 16 | Weighted sum in two's complement |
| rsp_valid | output | 1 | `rsp_act` answers the request of the previous cycle |
| rsp_act | output | 16 | Activation word read from the table |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Table word to write |
| host_wdata | input | 16 | Value to store |

## Verification
Every result is due exactly one clock edge after its stimulus:
- the response word and its valid flag follow the request edge by one cycle;
- a host write becomes visible to reads whose request edge comes after the write edge, while a read at the write edge itself still sees the old word.

The bench drives its inputs at the falling edge. At each rising edge it updates a behavioural table and the expected response. One nanosecond later it compares both outputs with that expectation, so every cycle is checked, idle ones included.

// File: rtl/act_lut_pkg.sv
package act_lut_pkg;

    // Response slot state of the read controller
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } lut_state_e;

endpackage

// File: rtl/act_lut_index.sv
// Maps a signed sum onto a table index, clamping outside the stored window.
module act_lut_index #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [DATA_W-1:0] sum_i,
    output logic [ADDR_W-1:0] idx_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic signed [DATA_W:0] OFFS = (DATA_W+1)'(DEPTH / 2);
    localparam logic signed [DATA_W:0] LAST = (DATA_W+1)'(DEPTH - 1);

    logic signed [DATA_W:0] shifted;

    always_comb begin
        shifted = $signed({sum_i[DATA_W-1], sum_i}) + OFFS;
        if (shifted[DATA_W]) begin
            idx_o = '0;
        end else if (shifted > LAST) begin
            idx_o = '1;
        end else begin
            idx_o = shifted[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/act_lut_mem.sv
// Single write port, single registered read port; read sees pre-write data.
module act_lut_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= words[rd_addr];
        end
    end
endmodule

// File: rtl/act_lut_ctrl.sv
// Tracks whether the response register holds a fresh answer.
module act_lut_ctrl
    import act_lut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rd_en_o,
    output logic valid_o
);
    lut_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i)  state_d = ST_SERVE;  // accept
            ST_SERVE: if (!req_i) state_d = ST_IDLE;   // drain; else chain
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_en_o = req_i;
        valid_o = (state_q == ST_SERVE);
    end
endmodule

// File: rtl/act_window_lut.sv
module act_window_lut #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_sum,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_act,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata
);
    logic [ADDR_W-1:0] rd_idx;
    logic              rd_en;

    act_lut_index #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_idx (
        .sum_i (req_sum),
        .idx_o (rd_idx)
    );

    act_lut_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_valid),
        .rd_en_o (rd_en),
        .valid_o (rsp_valid)
    );

    act_lut_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_we),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_idx),
        .rd_data (rsp_act)
    );
endmodule

// File: rtl/act_window_lut_chk.sv
module act_window_lut_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DATA_W-1:0] req_sum,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_act,
    input logic [ADDR_W-1:0] rd_idx
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic signed [DATA_W-1:0] WIN_LO = DATA_W'(-(DEPTH / 2));
    localparam logic signed [DATA_W-1:0] WIN_HI = DATA_W'(DEPTH / 2 - 1);

    // R2: a request yields a valid response one cycle later
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: no response without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6: data holds when nothing was requested
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_act));

    // R4: low clamp selects the first word
    a_r4_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($signed(req_sum) < WIN_LO)) |-> (rd_idx == '0));

    // R5: high clamp selects the last word
    a_r5_high_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($signed(req_sum) > WIN_HI)) |-> (rd_idx == '1));
endmodule

bind act_window_lut act_window_lut_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sum   (req_sum),
    .rsp_valid (rsp_valid),
    .rsp_act   (rsp_act),
    .rd_idx    (rd_idx)
);

// File: tb/sim_act_window_lut.sv
`timescale 1ns/1ps
module sim_act_window_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sum = '0;
    logic        rsp_valid;
    logic [15:0] rsp_act;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    logic [15:0] model [4096];
    logic        exp_v = 1'b0;
    logic [15:0] exp_a = '0;

    always #5 clk = ~clk;

    act_window_lut u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sum(req_sum),
        .rsp_valid(rsp_valid), .rsp_act(rsp_act), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata)
    );

    function automatic int ref_idx(input logic [15:0] s);
        int v = int'($signed(s));
        if (v < -2048) return 0;
        if (v > 2047) return 4095;
        return v + 2048;
    endfunction

    function automatic logic [15:0] curve(input int i);
        return 16'(i * 3 + 5);
    endfunction

    task automatic check(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v2,
                         input string what);
        tests++;
        if (act_v !== exp_v2) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act_v, exp_v2);
        end
    endtask

    task automatic step(input bit rv, input logic [15:0] s, input bit we,
                        input logic [11:0] a, input logic [15:0] d, input string tag);
        @(negedge clk);
        req_valid = rv; req_sum = s; host_we = we; host_addr = a; host_wdata = d;
        @(posedge clk);
        if (rv) begin
            exp_v = 1'b1;
            exp_a = model[ref_idx(s)];
        end else begin
            exp_v = 1'b0;
        end
        if (we) model[a] = d;
        #1;
        check(tag, {15'd0, rsp_valid}, {15'd0, exp_v}, "rsp_valid");
        check(tag, rsp_act, exp_a, "rsp_act");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) model[i] = 'x;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", {15'd0, rsp_valid}, 16'd0, "rsp_valid");
        check("R1", rsp_act, 16'd0, "rsp_act");
        rst_n = 1'b1;

        // preload; idle outputs must hold (R6)
        for (int i = 0; i < 4096; i++) step(0, 16'd0, 1, 12'(i), curve(i), "R6");

        // R3: in-window reads, back to back (R2)
        step(1, 16'hF800, 0, 0, 0, "R3");   // -2048 -> 0
        step(1, 16'h0000, 0, 0, 0, "R3");   // 0 -> 2048
        step(1, 16'h07FF, 0, 0, 0, "R3");   // 2047 -> 4095
        step(1, 16'hFFFF, 0, 0, 0, "R3");   // -1 -> 2047
        step(1, 16'h0123, 0, 0, 0, "R2");
        step(0, 16'h0000, 0, 0, 0, "R2");
        // R4: below window
        step(1, 16'hF7FF, 0, 0, 0, "R4");   // -2049
        step(1, 16'h8000, 0, 0, 0, "R4");   // -32768
        // R5: above window
        step(1, 16'h0800, 0, 0, 0, "R5");   // 2048
        step(1, 16'h7FFF, 0, 0, 0, "R5");   // 32767
        // R6: idle with host writes keeps output
        step(0, 16'h0000, 1, 12'd4095, 16'hAAAA, "R6");
        step(0, 16'h0000, 1, 12'd7, 16'h5555, "R6");
        // R7: reloaded words visible afterwards, neighbours untouched
        step(1, 16'h07FF, 0, 0, 0, "R7");
        step(1, 16'(7 - 2048), 0, 0, 0, "R7");
        step(1, 16'(8 - 2048), 0, 0, 0, "R7");
        // R8: same-edge write and read return old word
        step(1, 16'(100 - 2048), 1, 12'd100, 16'hBEEF, "R8");
        step(1, 16'(100 - 2048), 0, 0, 0, "R7");
        step(1, 16'h8000, 1, 12'd0, 16'h1234, "R8");
        step(1, 16'h8000, 0, 0, 0, "R7");
        // sweep a span of the window with interleaved idles
        for (int k = -2100; k < 2100; k += 97) begin
            step(1, 16'(k), 0, 0, 0, "R3");
            step(0, 16'(k), 0, 0, 0, "R6");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule